// File: doc/BRIEF.md
# Receive Identifier Acceptance Filter Bank

This block decides, for every received frame, whether the frame is kept and which receive buffer takes it. When the frame receiver reports a completed, valid frame, the identifier is compared against a bank of programmable filters in the same cycle. Each filter has an identifier value, a standard/extended flag, an enable bit, a choice of mask from a small shared mask pool and a destination buffer number. A mask bit at one means that identifier bit must equal the filter bit. A mask bit at zero means that bit is not compared.

Two routing modes are available. In the flexible mode any filter can be pointed at any receive buffer and at any mask at run time. When filters routed to different buffers all match, the lowest-numbered buffer takes the frame. In the fixed mode the association is hard-wired. Filters 0 and 1 share mask 0 and feed buffer 0. Filters 2 to 5 share mask 1 and feed buffer 1. The remaining filters are idle.

The decision is registered. An accept pulse, the winning buffer number and the index of the reporting filter appear one cycle after the frame strobe. A frame-assembly stage drives the inputs, and the buffer manager uses the outputs to pick the storage slot.

Top module: `id_accept_filter`

## Requirements
- R1: For each identifier bit whose selected mask bit is 0, the bit is accepted whatever the filter and identifier bits hold.
- R2: For each identifier bit whose selected mask bit is 1, the bit is accepted only when the identifier bit equals the filter bit.
- R3: A filter matches only when every compared bit is accepted and its extended flag (1 = extended) equals `frame_ext`. Extended frames compare bits 28:0. Standard frames compare only bits 10:0.
- R4: A filter whose `filt_en` bit is 0 never matches. When no filter matches, `acc_valid` stays 0.
- R5: With `mode_flex` = 1, filter f takes its destination buffer from `filt_buf[f*3 +: 3]` and its mask from `mask_val[m*29 +: 29]`, where m = `filt_msel[f*2 +: 2]`. Filter f's value is `filt_id[f*29 +: 29]`.
- R6: When matching filters lead to two or more buffers, the lowest buffer number wins. `acc_filt` then reports the lowest-numbered matching filter routed to that buffer.
- R7: With `mode_flex` = 0, filters 0 and 1 use mask 0 and feed buffer 0, and filters 2 to 5 use mask 1 and feed buffer 1. `filt_buf` and `filt_msel` are ignored, and filters 6 and above never match.
- R8: The outputs are registered. A decision is made only for a cycle with `frame_valid` = 1 and appears on the next clock edge. In any other cycle `acc_valid`, `acc_buf` and `acc_filt` are 0.
- R9: While `rst_n` is low, `acc_valid`, `acc_buf` and `acc_filt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_flex | input | 1 | 1 = flexible routing, 0 = fixed association |
| frame_valid | input | 1 | One-cycle strobe: a complete valid frame is present |
| frame_id | input | 29 | Frame identifier (standard ID in bits 10:0) |
| frame_ext | input | 1 | 1 = extended identifier frame |
| filt_id | input | 464 | Filter values, 29 bits per filter |
| filt_ext | input | 16 | Per-filter extended flag |
| filt_en | input | 16 | Per-filter enable |
| filt_buf | input | 48 | Per-filter destination buffer, 3 bits each |
| filt_msel | input | 32 | Per-filter mask select, 2 bits each |
| mask_val | input | 116 | Mask pool, 29 bits per mask |
| acc_valid | output | 1 | Frame accepted |
| acc_buf | output | 3 | Winning receive buffer |
| acc_filt | output | 4 | Reporting filter index |

## Verification
The bench builds the block with its defaults: 16 filters, 8 buffers, a pool of 4 masks and 29-bit identifiers. At these values every 3-bit routing code names a real buffer and every 2-bit mask select names a real mask. Random configurations can therefore produce conflicts across the whole buffer range, and every mask slot gets used. Directed frames cover the fixed mapping of filters 0 to 5, the idle upper filters, standard frames whose upper identifier bits differ from the filter, and tie-breaking among several filters routed to the same buffer.

// File: rtl/id_accept_filter.sv
module id_accept_filter #(
  parameter int NUM_FILT = 16,
  parameter int NUM_BUF  = 8,
  parameter int NUM_MASK = 4,
  parameter int ID_W     = 29,
  parameter int STD_W    = 11,
  localparam int BUF_W   = (NUM_BUF  > 1) ? $clog2(NUM_BUF)  : 1,
  localparam int FILT_W  = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
  localparam int MSEL_W  = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_flex,
  input  logic                       frame_valid,
  input  logic [ID_W-1:0]            frame_id,
  input  logic                       frame_ext,
  input  logic [NUM_FILT*ID_W-1:0]   filt_id,
  input  logic [NUM_FILT-1:0]        filt_ext,
  input  logic [NUM_FILT-1:0]        filt_en,
  input  logic [NUM_FILT*BUF_W-1:0]  filt_buf,
  input  logic [NUM_FILT*MSEL_W-1:0] filt_msel,
  input  logic [NUM_MASK*ID_W-1:0]   mask_val,
  output logic                       acc_valid,
  output logic [BUF_W-1:0]           acc_buf,
  output logic [FILT_W-1:0]          acc_filt
);

  logic [NUM_FILT-1:0] hit;
  logic [BUF_W-1:0]    route [NUM_FILT];
  logic [ID_W-1:0]     span;

  assign span = frame_ext ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    logic [MSEL_W-1:0] msel;
    logic [ID_W-1:0]   msk;
    logic              usable;

    assign msel     = mode_flex ? filt_msel[f*MSEL_W +: MSEL_W]
                                : ((f < 2) ? '0 : MSEL_W'(1));
    assign msk      = mask_val[msel*ID_W +: ID_W];
    assign route[f] = mode_flex ? filt_buf[f*BUF_W +: BUF_W]
                                : ((f < 2) ? '0 : BUF_W'(1));
    assign usable   = filt_en[f] && (mode_flex || (f < 6));
    assign hit[f]   = usable
                   && (filt_ext[f] == frame_ext)
                   && (((frame_id ^ filt_id[f*ID_W +: ID_W]) & msk & span) == '0)
                   && ({1'b0, route[f]} < (BUF_W+1)'(NUM_BUF));
  end

  logic              win_any;
  logic [BUF_W-1:0]  win_buf;
  logic [FILT_W-1:0] win_filt;

  always_comb begin
    win_any  = 1'b0;
    win_buf  = '0;
    win_filt = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      for (int fi = NUM_FILT - 1; fi >= 0; fi--) begin
        if (hit[fi] && (route[fi] == BUF_W'(b))) begin
          win_any  = 1'b1;
          win_buf  = BUF_W'(b);
          win_filt = FILT_W'(fi);
        end
      end
    end
  end

  logic take;
  assign take = frame_valid && win_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_buf   <= '0;
      acc_filt  <= '0;
    end else begin
      acc_valid <= take;
      acc_buf   <= take ? win_buf  : '0;
      acc_filt  <= take ? win_filt : '0;
    end
  end

endmodule

// File: rtl/id_accept_filter_chk.sv
module id_accept_filter_chk #(
  parameter int NUM_FILT = 16,
  parameter int BUF_W    = 3,
  parameter int FILT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_flex,
  input logic              frame_valid,
  input logic [NUM_FILT-1:0] filt_en,
  input logic              acc_valid,
  input logic [BUF_W-1:0]  acc_buf,
  input logic [FILT_W-1:0] acc_filt
);

  logic                prev_fv;
  logic                prev_flex;
  logic [NUM_FILT-1:0] prev_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fv   <= 1'b0;
      prev_flex <= 1'b0;
      prev_en   <= '0;
    end else begin
      prev_fv   <= frame_valid;
      prev_flex <= mode_flex;
      prev_en   <= filt_en;
    end
  end

  assert_accept_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> prev_fv);

  assert_idle_outputs_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_buf == '0 && acc_filt == '0));

  assert_winner_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> prev_en[acc_filt]);

  assert_fixed_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prev_flex) |->
      (acc_filt < FILT_W'(6)) && (acc_buf == ((acc_filt >= FILT_W'(2)) ? BUF_W'(1) : BUF_W'(0))));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R9: assert (!acc_valid || $isunknown(acc_valid));
    end
  end

endmodule

bind id_accept_filter id_accept_filter_chk #(
  .NUM_FILT(NUM_FILT), .BUF_W(BUF_W), .FILT_W(FILT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_flex(mode_flex), .frame_valid(frame_valid),
  .filt_en(filt_en), .acc_valid(acc_valid), .acc_buf(acc_buf), .acc_filt(acc_filt)
);

// File: tb/id_accept_filter_tb.sv
`timescale 1ns/1ps
module id_accept_filter_tb;
  localparam int NF = 16, NB = 8, NM = 4, IW = 29, BW = 3, FW = 4, MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_flex = 1'b1;
  logic frame_valid = 1'b0;
  logic [IW-1:0] frame_id = '0;
  logic frame_ext = 1'b0;
  logic [NF*IW-1:0] filt_id = '0;
  logic [NF-1:0] filt_ext = '0;
  logic [NF-1:0] filt_en = '0;
  logic [NF*BW-1:0] filt_buf = '0;
  logic [NF*MW-1:0] filt_msel = '0;
  logic [NM*IW-1:0] mask_val = '0;
  logic acc_valid;
  logic [BW-1:0] acc_buf;
  logic [FW-1:0] acc_filt;

  int checks = 0;
  int errors = 0;
  bit exp_v;
  int exp_b, exp_f;

  always #2.5 clk = ~clk;

  id_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .mode_flex(mode_flex), .frame_valid(frame_valid),
    .frame_id(frame_id), .frame_ext(frame_ext), .filt_id(filt_id), .filt_ext(filt_ext),
    .filt_en(filt_en), .filt_buf(filt_buf), .filt_msel(filt_msel), .mask_val(mask_val),
    .acc_valid(acc_valid), .acc_buf(acc_buf), .acc_filt(acc_filt)
  );

  function automatic void model();
    bit found = 0;
    logic [IW-1:0] span = frame_ext ? '1 : IW'(11'h7FF);
    exp_v = 0; exp_b = 0; exp_f = 0;
    for (int b = 0; b < NB && !found; b++) begin
      for (int f = 0; f < NF && !found; f++) begin
        int m = mode_flex ? int'(filt_msel[f*MW +: MW]) : ((f < 2) ? 0 : 1);
        int r = mode_flex ? int'(filt_buf[f*BW +: BW]) : ((f < 2) ? 0 : 1);
        bit ok = filt_en[f] && (mode_flex || f < 6) && (filt_ext[f] == frame_ext);
        for (int i = 0; i < IW; i++)
          if (span[i] && mask_val[m*IW + i] && (frame_id[i] != filt_id[f*IW + i])) ok = 0;
        if (ok && r == b) begin
          found = 1; exp_v = 1; exp_b = b; exp_f = f;
        end
      end
    end
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_out(input string tag, input bit v, input int b, input int f);
    chk(acc_valid == v, {tag, " valid"}, int'(acc_valid), int'(v));
    chk(int'(acc_buf) == b, {tag, " buf"}, int'(acc_buf), b);
    chk(int'(acc_filt) == f, {tag, " filt"}, int'(acc_filt), f);
  endtask

  task automatic send(input string tag, input bit v, input int b, input int f);
    @(negedge clk);
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    check_out(tag, v, b, f);
  endtask

  task automatic send_model(input string tag);
    model();
    send(tag, exp_v, exp_b, exp_f);
  endtask

  task automatic clear_cfg();
    filt_id = '0; filt_ext = '0; filt_en = '0; filt_buf = '0; filt_msel = '0; mask_val = '0;
  endtask

  task automatic set_f(input int f, input logic [IW-1:0] v, input bit ext, input int b, input int m);
    filt_id[f*IW +: IW] = v; filt_ext[f] = ext; filt_en[f] = 1'b1;
    filt_buf[f*BW +: BW] = BW'(b); filt_msel[f*MW +: MW] = MW'(m);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    frame_valid = 1'b1;
    check_out("R9 reset", 0, 0, 0);
    @(negedge clk);
    check_out("R9 reset strobe", 0, 0, 0);
    frame_valid = 1'b0;
    rst_n = 1'b1;

    // R4: all filters disabled
    clear_cfg(); mode_flex = 1; frame_ext = 1; frame_id = 29'h1ABCDEF0;
    for (int f = 0; f < NF; f++) begin set_f(f, frame_id, 1, 2, 0); end
    filt_en = '0;
    send("R4 disabled", 0, 0, 0);

    // R1: zero mask accepts any value
    clear_cfg(); set_f(3, 29'h0123_4567, 1, 5, 2);
    send("R1 zero mask", 1, 5, 3);

    // R2: one differing bit under full mask rejects
    clear_cfg(); mask_val[1*IW +: IW] = '1;
    set_f(7, frame_id ^ 29'h0000_0100, 1, 4, 1);
    send("R2 mismatch", 0, 0, 0);
    set_f(7, frame_id, 1, 4, 1);
    send("R2 match", 1, 4, 7);

    // R6: lowest buffer wins, lowest filter within it
    clear_cfg(); mask_val[0 +: IW] = '1;
    set_f(2, frame_id, 1, 6, 0); set_f(9, frame_id, 1, 1, 0); set_f(4, frame_id, 1, 1, 0);
    set_f(12, frame_id, 1, 3, 0);
    send("R6 priority", 1, 1, 4);

    // R3: extended flag mismatch, then standard frame with upper bits differing
    clear_cfg(); mask_val[0 +: IW] = '1; frame_ext = 0; frame_id = 29'h0ABC_D123;
    set_f(5, frame_id, 1, 2, 0);
    send("R3 ext flag", 0, 0, 0);
    set_f(5, {frame_id[IW-1:11] ^ 18'h3_FFFF, frame_id[10:0]}, 0, 2, 0);
    send("R3 std span", 1, 2, 5);
    set_f(5, frame_id ^ 29'h1, 0, 2, 0);
    send("R3 std low bit", 0, 0, 0);

    // R7: fixed mode
    clear_cfg(); mode_flex = 0; frame_ext = 1; frame_id = 29'h155_5555;
    mask_val[1*IW +: IW] = '1;
    set_f(3, frame_id, 1, 7, 3);
    set_f(8, frame_id, 1, 0, 0);
    send("R7 fixed buf1", 1, 1, 3);
    filt_en[3] = 1'b0;
    send("R7 upper idle", 0, 0, 0);
    set_f(1, 29'h0, 1, 6, 3);
    send("R7 fixed buf0", 1, 0, 1);

    // R8: no strobe, no decision
    @(negedge clk);
    check_out("R8 idle", 0, 0, 0);

    // R5 R6 random
    for (int n = 0; n < 400; n++) begin
      mode_flex = ($urandom_range(3) != 0);
      frame_ext = $urandom_range(1);
      frame_id = IW'($urandom);
      for (int m = 0; m < NM; m++) mask_val[m*IW +: IW] = IW'($urandom & $urandom);
      for (int f = 0; f < NF; f++) begin
        filt_id[f*IW +: IW] = ($urandom_range(1) != 0) ? frame_id ^ IW'($urandom & $urandom & $urandom) : IW'($urandom);
        filt_ext[f] = ($urandom_range(3) != 0) ? frame_ext : ~frame_ext;
        filt_en[f] = ($urandom_range(2) != 0);
        filt_buf[f*BW +: BW] = BW'($urandom);
        filt_msel[f*MW +: MW] = MW'($urandom);
      end
      send_model("R5 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule